// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits next to a processor whose bus-control pins have been repurposed as a 3-bit cycle status code. It watches that code on every clock edge and rebuilds the separate strobes that memory and I/O devices expect. These are an address latch enable, a data-buffer enable, a transfer-direction line, and five active-low commands: memory read, memory write, I/O read, I/O write and interrupt acknowledge.

A bus cycle begins when the status code leaves the idle value 111. The block then spends one clock in an address phase, where the latch enable pulses high. After that it enters a command phase, where the decoded command strobe and the data enable are held. The cycle lasts until the status reads 111 again. The code captured at the start of a cycle governs the whole cycle, so a later change in the status has no effect until the code goes back to idle.

Top module: `busCmdGen`

## Requirements
- R1: While reset is high, and after it is released, all five command strobes are high, addrLatchEn and dataEn are low, and dirTxRxN is high. After reset, a cycle starts only once the status has been sampled at 111 at least once, so a non-111 status present at reset release starts nothing.
- R2: When the status is sampled at a non-111 code on the edge after an edge that sampled 111, addrLatchEn is high for exactly the following clock, and every command strobe stays high during that clock.
- R3: The command phase starts on the clock after the addrLatchEn pulse. The command strobe stays asserted on every clock for as long as the status is sampled at a non-111 value.
- R4: On the first edge that samples status 111 during the command phase, all command strobes and dataEn are released, and dirTxRxN returns high.
- R5: Code 000 (interrupt acknowledge) drives intAckN low during the command phase.
- R6: Code 001 (I/O read) drives ioRdN low, and code 010 (I/O write) drives ioWrN low.
- R7: Code 011 (halt) runs the address and command phases but drives no command strobe low and keeps dataEn low.
- R8: Codes 100 (code fetch) and 101 (memory read) drive memRdN low, and code 110 (memory write) drives memWrN low.
- R9: During both phases of a cycle, dirTxRxN is low for codes 000, 001, 100 and 101. It is high for codes 010, 110 and 011, and high when no cycle is in progress.
- R10: dataEn is high during the command phase for every code except 011, and low at all other times.
- R11: If the status changes to another non-111 code after a cycle has started, the strobes, dataEn and dirTxRxN keep following the code captured at the start of the cycle.
- R12: At most one command strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busStatus | input | 3 | Cycle status code from the processor; 111 means idle |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| intAckN | output | 1 | Interrupt acknowledge command, active low |
| addrLatchEn | output | 1 | Address latch enable, high for one clock at the start of a cycle |
| dataEn | output | 1 | Data buffer enable, active high |
| dirTxRxN | output | 1 | Transfer direction: low means receive (read), high means transmit |

## Verification
The hardest situation to reach from the ports is a status change in the middle of a cycle. The outputs must keep showing the captured code even though the pins now carry a different valid code. To reach it, the stimulus switches to a different non-idle code right after the address phase and keeps it there through command phases of one to three clocks. Every code is swept this way, each with and without the change. The other awkward case is reset release with the bus already showing an active code, which the stimulus creates by holding a memory-read code through reset.

// File: rtl/busCmdPkg.sv
package busCmdPkg;
  localparam int STS_W = 3;
  typedef logic [STS_W-1:0] stsCode_t;

  localparam stsCode_t ST_INTA    = 3'b000;
  localparam stsCode_t ST_IORD    = 3'b001;
  localparam stsCode_t ST_IOWR    = 3'b010;
  localparam stsCode_t ST_HALT    = 3'b011;
  localparam stsCode_t ST_CODE    = 3'b100;
  localparam stsCode_t ST_MEMRD   = 3'b101;
  localparam stsCode_t ST_MEMWR   = 3'b110;
  localparam stsCode_t ST_PASSIVE = 3'b111;

  // strobes from the sequencer to the status path
  typedef struct packed {
    logic latchCode;
    logic aleOn;
    logic cmdOn;
    logic inCycle;
  } ctrlStrb_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_CMD} seqState_t;
endpackage

// File: rtl/statusPath.sv
module statusPath
  import busCmdPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  stsCode_t  busStatus,
  input  ctrlStrb_t ctrl,
  output logic      startSeen,
  output logic      endSeen,
  output logic      memRdN,
  output logic      memWrN,
  output logic      ioRdN,
  output logic      ioWrN,
  output logic      intAckN,
  output logic      addrLatchEn,
  output logic      dataEn,
  output logic      dirTxRxN
);
  logic     passiveQ;
  stsCode_t codeQ;
  logic     isRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      passiveQ <= 1'b0;
      codeQ    <= ST_PASSIVE;
    end else begin
      passiveQ <= (busStatus == ST_PASSIVE);
      if (ctrl.latchCode) codeQ <= busStatus;
    end
  end

  always_comb begin
    startSeen   = passiveQ && (busStatus != ST_PASSIVE);
    endSeen     = (busStatus == ST_PASSIVE);
    isRead      = (codeQ == ST_INTA) || (codeQ == ST_IORD) ||
                  (codeQ == ST_CODE) || (codeQ == ST_MEMRD);
    intAckN     = !(ctrl.cmdOn && codeQ == ST_INTA);
    ioRdN       = !(ctrl.cmdOn && codeQ == ST_IORD);
    ioWrN       = !(ctrl.cmdOn && codeQ == ST_IOWR);
    memRdN      = !(ctrl.cmdOn && (codeQ == ST_CODE || codeQ == ST_MEMRD));
    memWrN      = !(ctrl.cmdOn && codeQ == ST_MEMWR);
    dataEn      = ctrl.cmdOn && (codeQ != ST_HALT);
    dirTxRxN    = !(ctrl.inCycle && isRead);
    addrLatchEn = ctrl.aleOn;
  end

  // R11: captured code does not move during the command phase
  a_r11_code_held: assert property (@(posedge clk) disable iff (rst)
    ctrl.cmdOn |-> $stable(codeQ));

  // R12: never more than one command strobe active
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({~memRdN, ~memWrN, ~ioRdN, ~ioWrN, ~intAckN}) <= 1);

  // R7: halt drives no command and no data enable
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctrl.inCycle && codeQ == ST_HALT) |->
      (&{memRdN, memWrN, ioRdN, ioWrN, intAckN}) && !dataEn);
endmodule

// File: rtl/cmdSequencer.sv
module cmdSequencer
  import busCmdPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startSeen,
  input  logic      endSeen,
  output ctrlStrb_t ctrl
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SEQ_IDLE: if (startSeen) stateD = SEQ_ADDR;
      SEQ_ADDR: stateD = SEQ_CMD;
      SEQ_CMD:  if (endSeen) stateD = SEQ_IDLE;
      default:  stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= SEQ_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    ctrl.latchCode = (stateQ == SEQ_IDLE) && startSeen;
    ctrl.aleOn     = (stateQ == SEQ_ADDR);
    ctrl.cmdOn     = (stateQ == SEQ_CMD);
    ctrl.inCycle   = (stateQ != SEQ_IDLE);
  end

  // R2/R3: the address phase lasts one clock and leads to the command phase
  a_r2_addr_single: assert property (@(posedge clk) disable iff (rst)
    (stateQ == SEQ_ADDR) |=> (stateQ == SEQ_CMD));

  // R3: command phase holds while the status stays active
  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (stateQ == SEQ_CMD && !endSeen) |=> (stateQ == SEQ_CMD));

  // R4: idle status ends the command phase on the next edge
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (stateQ == SEQ_CMD && endSeen) |=> (stateQ == SEQ_IDLE));
endmodule

// File: rtl/busCmdGen.sv
module busCmdGen
  import busCmdPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] busStatus,
  output logic       memRdN,
  output logic       memWrN,
  output logic       ioRdN,
  output logic       ioWrN,
  output logic       intAckN,
  output logic       addrLatchEn,
  output logic       dataEn,
  output logic       dirTxRxN
);
  ctrlStrb_t ctrl;
  logic      startSeen, endSeen;

  cmdSequencer uSeq (
    .clk(clk), .rst(rst), .startSeen(startSeen), .endSeen(endSeen), .ctrl(ctrl)
  );

  statusPath uPath (
    .clk(clk), .rst(rst), .busStatus(busStatus), .ctrl(ctrl),
    .startSeen(startSeen), .endSeen(endSeen),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .intAckN(intAckN), .addrLatchEn(addrLatchEn), .dataEn(dataEn),
    .dirTxRxN(dirTxRxN)
  );

  // R2: the latch enable is a single-clock pulse
  a_r2_ale_pulse: assert property (@(posedge clk) disable iff (rst)
    addrLatchEn |=> !addrLatchEn);

  // R10: data enable is never on together with the latch enable
  a_r10_den_not_ale: assert property (@(posedge clk) disable iff (rst)
    !(addrLatchEn && dataEn));
endmodule

// File: tb/tb_busCmdGen.sv
module tb_busCmdGen;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] busStatus;
  logic memRdN, memWrN, ioRdN, ioWrN, intAckN, addrLatchEn, dataEn, dirTxRxN;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  busCmdGen dut (
    .clk(clk), .rst(rst), .busStatus(busStatus),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .intAckN(intAckN), .addrLatchEn(addrLatchEn), .dataEn(dataEn),
    .dirTxRxN(dirTxRxN)
  );

  // vector: {ale, den, dir, intAckN, ioRdN, ioWrN, memRdN, memWrN}
  function automatic logic [7:0] expVec(int phase, logic [2:0] code);
    logic rd;
    logic [4:0] cmd;
    rd  = (code == 3'd0) || (code == 3'd1) || (code == 3'd4) || (code == 3'd5);
    cmd = 5'b11111;
    if (phase == 2) begin
      if (code == 3'd0) cmd[4] = 1'b0;
      if (code == 3'd1) cmd[3] = 1'b0;
      if (code == 3'd2) cmd[2] = 1'b0;
      if (code == 3'd4 || code == 3'd5) cmd[1] = 1'b0;
      if (code == 3'd6) cmd[0] = 1'b0;
    end
    if (phase == 0) return 8'b0011_1111;
    return {phase == 1, (phase == 2) && (code != 3'd3), !rd, cmd};
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    logic [7:0] act;
    act = {addrLatchEn, dataEn, dirTxRxN, intAckN, ioRdN, ioWrN, memRdN, memWrN};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic runCycle(logic [2:0] code, int hold, bit midChange);
    logic [2:0] other;
    other = 3'((int'(code) + 3) % 7);
    @(negedge clk) busStatus = 3'b111;
    @(negedge clk) busStatus = code;
    @(negedge clk) check("R2/R9 address phase", expVec(1, code));
    if (midChange) busStatus = other;   // R11: later code must be ignored
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(midChange ? "R11 mid-cycle change" : "R3/R5/R6/R7/R8/R9/R10 command",
            expVec(2, code));
    end
    busStatus = 3'b111;
    @(negedge clk) check("R4 release", expVec(0, code));
  endtask

  initial begin
    rst = 1'b1;
    busStatus = 3'b101;
    repeat (3) @(negedge clk);
    check("R1 in reset", expVec(0, 3'd0));
    rst = 1'b0;
    repeat (4) @(negedge clk) check("R1 no start without idle", expVec(0, 3'd0));
    for (int c = 0; c < 7; c++)
      for (int h = 1; h <= 3; h++)
        for (int m = 0; m < 2; m++)
          runCycle(3'(c), h, m[0]);
    // R12 covered by per-code strobe vector checks; back-to-back cycles
    @(negedge clk) busStatus = 3'b110;
    @(negedge clk) check("R2 back-to-back start", expVec(1, 3'd6));
    @(negedge clk) check("R8 back-to-back write", expVec(2, 3'd6));
    busStatus = 3'b111;
    @(negedge clk) check("R4 back-to-back release", expVec(0, 3'd6));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule